// File: doc/BRIEF.md
# Compressed-Addend 3x3 Gaussian Smoothing Datapath

This block smooths 8-bit grayscale images with a 3x3 Gaussian kernel. Each cycle it can accept one full 3x3 neighbourhood of pixels, qualified by a valid strobe. After a fixed pipeline delay it returns one smoothed pixel with its own valid strobe. Upstream logic forms the window, including line buffering and border handling.

The kernel weights are 1 at the corners, 2 at the edges and 4 at the centre, and they sum to 16. The datapath uses no multipliers and no dividers. Each weight is a wired left shift and the normalisation is a wired right shift. The nine weighted terms go through three compression levels. The first level uses carry-save adders. The second and third levels use 4-2 compressors, each built from two multiplexers per bit. A single carry-propagate adder then resolves the last sum and carry vectors.

The window arrives flattened on one bus. The pixel at row r and column c (each 0..2) sits at bit offset 8*(3*r+c).

Top module: `blur3x3_filter`

## Requirements
- R1: While reset is held, and at the first sample after it is released, outValid is 0 and outPix is 0.
- R2: Each result equals floor(S/16), where S is the sum of each window pixel times its weight. The weight is 4 for index 4 (centre), 2 for indices 1, 3, 5 and 7, and 1 for indices 0, 2, 6 and 8. Index k = 3*r+c occupies winPix bits [8k+7:8k].
- R3: A window sampled with inValid high at rising edge n produces outValid high after rising edge n+3. This means the result is visible four edges after the input is set up. Exactly one result is produced for each accepted window.
- R4: Windows presented on consecutive cycles give one result per cycle, in input order, with no stall or bubble.
- R5: No intermediate value overflows. An all-255 window gives 255 and an all-zero window gives 0.
- R6: While outValid is 0, outPix keeps the last result. A window presented with inValid low yields no result and leaves outPix unchanged.
- R7: Each weight is applied at its own position. A lone 255 gives 63 at the centre, 31 at an edge position and 15 at a corner position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies winPix in this cycle |
| winPix | input | 72 | Nine 8-bit pixels, index 3*row+col at bits [8k+7:8k] |
| outValid | output | 1 | Qualifies outPix |
| outPix | output | 8 | Smoothed pixel |

## Verification
Loading a new window into the first compression level and releasing an older result from the final adder can happen in the same cycle. Every pipeline stage can also be loading at once. The bench provokes this with unbroken streams of random windows, followed by streams whose valid strobe is switched off and on. This makes stage enables start and stop while older results are still draining. Each cycle's outputs are compared against a shift-and-sum model that is indexed four cycles back. During idle cycles, outPix is expected to hold the last result.

// File: rtl/blur3x3_pkg.sv
package blur3x3_pkg;
  localparam int PIX_W   = 8;
  localparam int KSIDE   = 3;
  localparam int TAPS    = KSIDE * KSIDE;
  localparam int NORM_SH = 4;
  localparam int ACC_W   = PIX_W + NORM_SH;
  localparam int WIN_W   = TAPS * PIX_W;

  typedef logic [ACC_W-1:0] accT;

  typedef struct packed {
    logic loadL1;
    logic loadL2;
    logic loadL3;
    logic loadOut;
  } stageStrobeT;
endpackage

// File: rtl/blur3x3_csa.sv
module blur3x3_csa #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] sumV,
  output logic [WIDTH-1:0] carryV
);
  assign sumV = opA ^ opB ^ opC;
  assign carryV[0] = 1'b0;
  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_maj
      assign carryV[i] = (opA[i-1] & opB[i-1]) | (opA[i-1] & opC[i-1]) | (opB[i-1] & opC[i-1]);
    end
  endgenerate
endmodule

// File: rtl/blur3x3_comp42.sv
module blur3x3_comp42 #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [WIDTH-1:0] opD,
  output logic [WIDTH-1:0] sumV,
  output logic [WIDTH-1:0] carryV
);
  logic [WIDTH-1:0] parity;
  logic [WIDTH-1:0] cinV;

  assign cinV[0]   = 1'b0;
  assign carryV[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign parity[i] = opA[i] ^ opB[i] ^ opC[i] ^ opD[i];
      assign sumV[i]   = parity[i] ^ cinV[i];
      if (i < WIDTH - 1) begin : g_carry
        assign cinV[i+1]   = (opA[i] ^ opB[i]) ? opC[i] : opA[i];
        assign carryV[i+1] = parity[i] ? cinV[i] : opD[i];
      end
    end
  endgenerate
endmodule

// File: rtl/blur3x3_ctrl.sv
module blur3x3_ctrl
  import blur3x3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output stageStrobeT strobes,
  output logic        outValid
);
  localparam int STAGES = 4;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.loadL1  = inValid;
    strobes.loadL2  = validPipe[0];
    strobes.loadL3  = validPipe[1];
    strobes.loadOut = validPipe[2];
  end

  assign outValid = validPipe[STAGES-1];
endmodule

// File: rtl/blur3x3_datapath.sv
module blur3x3_datapath
  import blur3x3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobeT      strobes,
  input  logic [WIN_W-1:0] winPix,
  output logic [PIX_W-1:0] outPix
);
  localparam int L1_OUT = 2 * KSIDE;

  accT addend [TAPS];

  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_weight
      localparam int ROW = k / KSIDE;
      localparam int COL = k % KSIDE;
      localparam int SH  = ((ROW == 1) ? 1 : 0) + ((COL == 1) ? 1 : 0);
      assign addend[k] = accT'(winPix[k*PIX_W +: PIX_W]) << SH;
    end
  endgenerate

  // Level 1: one carry-save adder per kernel row
  accT l1Comb [L1_OUT];
  accT l1Reg  [L1_OUT];

  genvar r;
  generate
    for (r = 0; r < KSIDE; r++) begin : g_row
      blur3x3_csa #(.WIDTH(ACC_W)) rowCsa (
        .opA   (addend[r*KSIDE]),
        .opB   (addend[r*KSIDE+1]),
        .opC   (addend[r*KSIDE+2]),
        .sumV  (l1Comb[2*r]),
        .carryV(l1Comb[2*r+1])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < L1_OUT; i++) l1Reg[i] <= '0;
    end else if (strobes.loadL1) begin
      for (int i = 0; i < L1_OUT; i++) l1Reg[i] <= l1Comb[i];
    end
  end

  // Level 2: rows 0 and 1 through a 4-2 compressor, row 2 passes
  accT l2Sum, l2Carry;
  accT l2Reg [4];

  blur3x3_comp42 #(.WIDTH(ACC_W)) lvl2Comp (
    .opA   (l1Reg[0]),
    .opB   (l1Reg[1]),
    .opC   (l1Reg[2]),
    .opD   (l1Reg[3]),
    .sumV  (l2Sum),
    .carryV(l2Carry)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) l2Reg[i] <= '0;
    end else if (strobes.loadL2) begin
      l2Reg[0] <= l2Sum;
      l2Reg[1] <= l2Carry;
      l2Reg[2] <= l1Reg[4];
      l2Reg[3] <= l1Reg[5];
    end
  end

  // Level 3: final 4-2 compressor
  accT l3Sum, l3Carry;
  accT l3SumReg, l3CarryReg;

  blur3x3_comp42 #(.WIDTH(ACC_W)) lvl3Comp (
    .opA   (l2Reg[0]),
    .opB   (l2Reg[1]),
    .opC   (l2Reg[2]),
    .opD   (l2Reg[3]),
    .sumV  (l3Sum),
    .carryV(l3Carry)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l3SumReg   <= '0;
      l3CarryReg <= '0;
    end else if (strobes.loadL3) begin
      l3SumReg   <= l3Sum;
      l3CarryReg <= l3Carry;
    end
  end

  // Single carry-propagate adder and normalising shift
  accT totalV;
  logic [NORM_SH-1:0] unusedLowBits;

  assign totalV        = l3SumReg + l3CarryReg;
  assign unusedLowBits = totalV[NORM_SH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outPix <= '0;
    else if (strobes.loadOut)  outPix <= totalV[ACC_W-1:NORM_SH];
  end
endmodule

// File: rtl/blur3x3_filter.sv
module blur3x3_filter
  import blur3x3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIN_W-1:0] winPix,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);
  stageStrobeT strobes;

  blur3x3_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  blur3x3_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .winPix (winPix),
    .outPix (outPix)
  );
endmodule

// File: rtl/blur3x3_checker.sv
module blur3x3_checker
  import blur3x3_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIN_W-1:0] winPix,
  input logic             outValid,
  input logic [PIX_W-1:0] outPix
);
  localparam int DEPTH = 4;

  int unsigned      refNow;
  logic [PIX_W-1:0] refPipe [DEPTH];
  logic [DEPTH-1:0] vPipe;
  logic             wasInReset = 1'b0;

  always_comb begin
    refNow = 0;
    for (int k = 0; k < TAPS; k++) begin
      refNow += int'(winPix[k*PIX_W +: PIX_W]) *
                (((k / KSIDE) == 1) ? 2 : 1) * (((k % KSIDE) == 1) ? 2 : 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
      for (int i = 0; i < DEPTH; i++) refPipe[i] <= '0;
    end else begin
      vPipe      <= {vPipe[DEPTH-2:0], inValid};
      refPipe[0] <= PIX_W'(refNow / 16);
      for (int i = 1; i < DEPTH; i++) refPipe[i] <= refPipe[i-1];
    end
  end

  always_ff @(posedge clk) wasInReset <= !rstN;

  always @(posedge clk) begin
    if (wasInReset) assert_reset_clear_R1: assert (!outValid && outPix == '0);
  end

  assert_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outPix == refPipe[DEPTH-1]));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vPipe[DEPTH-1]);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outPix));
endmodule

bind blur3x3_filter blur3x3_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .winPix  (winPix),
  .outValid(outValid),
  .outPix  (outPix)
);

// File: tb/blur3x3_filter_tb_top.sv
module blur3x3_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXSEQ     = 64;
  localparam int LAT        = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [71:0] winPix = '0;
  logic        outValid;
  logic [7:0]  outPix;

  int checks = 0;
  int fails  = 0;

  logic [71:0] seqWin [MAXSEQ];
  bit          seqVal [MAXSEQ];
  int          seqLen;
  logic [7:0]  lastOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blur3x3_filter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .winPix(winPix),
    .outValid(outValid), .outPix(outPix)
  );

  function automatic logic [7:0] modelPix(input logic [71:0] w);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += int'(w[(3*r+c)*8 +: 8]) * ((r == 1) ? 2 : 1) * ((c == 1) ? 2 : 1);
    return 8'(s / 16);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Plays seqWin/seqVal and checks every cycle, result expected LAT iterations later
  task automatic runSeq(input string req);
    for (int c = 0; c < seqLen + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        check(outValid == seqVal[c-LAT], {req, " valid"}, outValid, seqVal[c-LAT]);
        if (seqVal[c-LAT]) lastOut = modelPix(seqWin[c-LAT]);
        check(outPix == lastOut, {req, " pixel"}, outPix, lastOut);
      end
      if (c < seqLen) begin
        winPix  = seqWin[c];
        inValid = seqVal[c];
      end else begin
        winPix  = '0;
        inValid = 1'b0;
      end
    end
  endtask

  task automatic testReset;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    check(outPix == 8'd0, "R1 pixel in reset", outPix, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid after release", outValid, 0);
    check(outPix == 8'd0, "R1 pixel after release", outPix, 0);
    lastOut = '0;
  endtask

  task automatic testExtremes;
    seqLen = 3;
    seqWin[0] = {9{8'hFF}}; seqVal[0] = 1;
    seqWin[1] = '0;         seqVal[1] = 1;
    seqWin[2] = {9{8'hFF}}; seqVal[2] = 1;
    runSeq("R5 R3 extremes");
  endtask

  task automatic testImpulses;
    seqLen = 0;
    for (int k = 0; k < 9; k++) begin
      seqWin[seqLen] = 72'(8'hFF) << (8*k);
      seqVal[seqLen] = 1;
      seqLen++;
      seqWin[seqLen] = '0;
      seqVal[seqLen] = 0;
      seqLen++;
    end
    runSeq("R7 impulse");
    // explicit spot values: centre, edge, corner
    check(modelPix(72'(8'hFF) << 32) == 8'd63, "R7 centre weight", modelPix(72'(8'hFF) << 32), 63);
    check(modelPix(72'(8'hFF) << 8)  == 8'd31, "R7 edge weight", modelPix(72'(8'hFF) << 8), 31);
    check(modelPix(72'(8'hFF))       == 8'd15, "R7 corner weight", modelPix(72'(8'hFF)), 15);
  endtask

  task automatic testStream;
    seqLen = 40;
    for (int i = 0; i < seqLen; i++) begin
      seqWin[i] = {$urandom, $urandom, $urandom};
      seqVal[i] = 1;
    end
    runSeq("R4 R2 back-to-back");
  endtask

  task automatic testGaps;
    seqLen = 48;
    for (int i = 0; i < seqLen; i++) begin
      seqWin[i] = {$urandom, $urandom, $urandom};
      seqVal[i] = ($urandom % 3) != 0;
    end
    runSeq("R6 R2 gapped");
    // idle with junk on the window bus and valid low
    seqLen = 10;
    for (int i = 0; i < seqLen; i++) begin
      seqWin[i] = {$urandom, $urandom, $urandom};
      seqVal[i] = 0;
    end
    runSeq("R6 ignored");
  endtask

  initial begin
    testReset;
    testExtremes;
    testImpulses;
    testStream;
    testGaps;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule